// File: doc/BRIEF.md
# UART Channel Mode Data Router

This block steers bytes between four byte-wide streams of a UART: bytes coming in from the serial line receiver, bytes written by the host into the data register, the receive FIFO and the serial transmitter. A two-bit channel mode selects one of four routings. These are ordinary operation, automatic echo, local loopback and remote loopback. Every side uses a valid/ready handshake. A transfer completes on a clock edge where both valid and ready are high.

In the echo and remote loopback routings, line bytes are sent back out on the transmitter without software involvement, and the host's writes are swallowed. A byte that goes to two destinations is taken only when both can take it, so neither copy is lost. A line break arrives as a flagged line byte and is handed to the receive path as an all-zero byte. The block samples the mode input only between bytes. A byte already offered finishes under the routing it started with.

Top module: `chmode_router`

## Requirements
- R1: Synchronous reset puts the active routing in normal mode (code 0), whatever `mode_i` holds during reset.
- R2: In normal mode (code 0), line bytes go only to the receive FIFO and host bytes go only to the transmitter.
- R3: In echo mode (code 1), a non-break line byte goes to both the receive FIFO and the transmitter with the same value. Host bytes are accepted at once (`host_ready_o` = 1) and appear on no output.
- R4: In local loopback mode (code 2), host bytes go to the receive FIFO and never to the transmitter. Line bytes, breaks included, are accepted at once and appear on no output.
- R5: In remote loopback mode (code 3), non-break line bytes go only to the transmitter. Host bytes are accepted at once and dropped. Nothing reaches the receive FIFO.
- R6: A line byte flagged as a break (`line_break_i` = 1) reaches the receive FIFO as 0x00 in modes 0 and 1. It is never sent to the transmitter. In modes 2 and 3 it is accepted and dropped.
- R7: When a line byte has two destinations, `line_ready_o` is high only when both `rxf_ready_i` and `tx_ready_i` are high. Neither destination sees valid unless the other destination is ready.
- R8: The active mode follows `mode_i` one edge after a cycle with no offered-but-unaccepted byte on either source. While such a byte is pending, the active mode does not change.
- R9: For a single-destination byte, the source ready equals that destination's ready, and the destination valid equals the source valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Requested channel mode: 0 normal, 1 echo, 2 local loopback, 3 remote loopback |
| line_valid_i | input | 1 | Receiver offers a line byte |
| line_data_i | input | 8 | Received line byte |
| line_break_i | input | 1 | Offered line item is a break condition |
| line_ready_o | output | 1 | Line byte accepted |
| host_valid_i | input | 1 | Host offers a written byte |
| host_data_i | input | 8 | Host-written byte |
| host_ready_o | output | 1 | Host byte accepted |
| rxf_valid_o | output | 1 | Byte offered to receive FIFO |
| rxf_data_o | output | 8 | Byte for receive FIFO |
| rxf_ready_i | input | 1 | Receive FIFO can take a byte |
| tx_valid_o | output | 1 | Byte offered to transmitter |
| tx_data_o | output | 8 | Byte for transmitter |
| tx_ready_i | input | 1 | Transmitter can take a byte |

## Verification
The hardest situation to reach from the ports is a mode change that arrives while a byte is stalled. The new mode must be held off until that byte completes, and then take effect for the next byte. The bench creates this case deliberately. It offers a line byte in normal mode with the receive FIFO stalled, then requests remote loopback for several cycles, then releases the stall. It checks that the stalled byte still goes to the FIFO and that the following byte goes to the transmitter. The rest of the stimulus is a full sweep, in every mode, of both source valids, the break flag and both destination readies.

// File: rtl/chmode_pkg.sv
package chmode_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        CM_NORMAL = 2'd0,
        CM_ECHO   = 2'd1,
        CM_LOCAL  = 2'd2,
        CM_REMOTE = 2'd3
    } cm_mode_e;

    typedef struct packed {
        logic line_rx;
        logic line_tx;
        logic host_rx;
        logic host_tx;
    } cm_route_t;

    function automatic cm_route_t cm_route(cm_mode_e m, logic brk);
        cm_route_t r;
        r.line_rx = (m == CM_NORMAL) || (m == CM_ECHO);
        r.line_tx = ((m == CM_ECHO) || (m == CM_REMOTE)) && !brk;
        r.host_rx = (m == CM_LOCAL);
        r.host_tx = (m == CM_NORMAL);
        return r;
    endfunction

endpackage

// File: rtl/chmode_mode_hold.sv
module chmode_mode_hold
    import chmode_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     busy,
    input  logic [1:0] mode_req,
    output cm_mode_e mode_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= CM_NORMAL;
        end else if (!busy) begin
            mode_q <= cm_mode_e'(mode_req);
        end
    end
endmodule

// File: rtl/chmode_route_dec.sv
module chmode_route_dec
    import chmode_pkg::*;
(
    input  cm_mode_e  mode,
    input  logic      brk,
    output cm_route_t route
);
    always_comb begin
        route = cm_route(mode, brk);
    end
endmodule

// File: rtl/chmode_steer.sv
module chmode_steer
    import chmode_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  cm_route_t     route,
    input  logic          lv,
    input  logic [W-1:0]  ld,
    input  logic          lbrk,
    output logic          lr,
    input  logic          hv,
    input  logic [W-1:0]  hd,
    output logic          hr,
    output logic          rv,
    output logic [W-1:0]  rd,
    input  logic          rr,
    output logic          tv,
    output logic [W-1:0]  td,
    input  logic          tr
);
    localparam logic [W-1:0] BREAK_BYTE = '0;

    logic [W-1:0] line_byte;
    logic rx_ok, tx_ok;

    always_comb begin
        line_byte = lbrk ? BREAK_BYTE : ld;
        rx_ok = !route.line_rx || rr;
        tx_ok = !route.line_tx || tr;
        lr = rx_ok && tx_ok;
        hr = (!route.host_rx || rr) && (!route.host_tx || tr);
        rv = (lv && route.line_rx && tx_ok) || (hv && route.host_rx);
        tv = (lv && route.line_tx && rx_ok) || (hv && route.host_tx);
        rd = route.host_rx ? hd : line_byte;
        td = route.host_tx ? hd : ld;
    end
endmodule

// File: rtl/chmode_router.sv
module chmode_router
    import chmode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic              line_valid_i,
    input  logic [DATA_W-1:0] line_data_i,
    input  logic              line_break_i,
    output logic              line_ready_o,
    input  logic              host_valid_i,
    input  logic [DATA_W-1:0] host_data_i,
    output logic              host_ready_o,
    output logic              rxf_valid_o,
    output logic [DATA_W-1:0] rxf_data_o,
    input  logic              rxf_ready_i,
    output logic              tx_valid_o,
    output logic [DATA_W-1:0] tx_data_o,
    input  logic              tx_ready_i
);
    cm_mode_e  mode_q;
    cm_route_t route;
    logic      busy;

    always_comb begin
        busy = (line_valid_i && !line_ready_o) || (host_valid_i && !host_ready_o);
    end

    chmode_mode_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .busy     (busy),
        .mode_req (mode_i),
        .mode_q   (mode_q)
    );

    chmode_route_dec u_dec (
        .mode  (mode_q),
        .brk   (line_break_i),
        .route (route)
    );

    chmode_steer #(.W(DATA_W)) u_steer (
        .route (route),
        .lv    (line_valid_i),
        .ld    (line_data_i),
        .lbrk  (line_break_i),
        .lr    (line_ready_o),
        .hv    (host_valid_i),
        .hd    (host_data_i),
        .hr    (host_ready_o),
        .rv    (rxf_valid_o),
        .rd    (rxf_data_o),
        .rr    (rxf_ready_i),
        .tv    (tx_valid_o),
        .td    (tx_data_o),
        .tr    (tx_ready_i)
    );
endmodule

// File: rtl/chmode_router_chk.sv
module chmode_router_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_q,
    input logic       line_valid_i,
    input logic       line_break_i,
    input logic       line_ready_o,
    input logic       host_valid_i,
    input logic       host_ready_o,
    input logic       rxf_valid_o,
    input logic [7:0] rxf_data_o,
    input logic       rxf_ready_i,
    input logic       tx_valid_o,
    input logic       tx_ready_i
);
    logic pending;
    always_comb begin
        pending = (line_valid_i && !line_ready_o) || (host_valid_i && !host_ready_o);
    end

    p_mode_held_r8: assert property (@(posedge clk) disable iff (rst)
        pending |=> $stable(mode_q));

    p_both_ready_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd1 && line_valid_i && !line_break_i && line_ready_o)
            |-> (rxf_ready_i && tx_ready_i));

    p_break_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (line_valid_i && line_break_i && rxf_valid_o && mode_q != 2'd2)
            |-> (rxf_data_o == 8'h00));

    p_remote_no_rx_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd3) |-> !rxf_valid_o);

    p_local_no_tx_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd2) |-> !tx_valid_o);

    p_echo_host_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd1 && host_valid_i) |-> host_ready_o);
endmodule

bind chmode_router chmode_router_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_q       (mode_q),
    .line_valid_i (line_valid_i),
    .line_break_i (line_break_i),
    .line_ready_o (line_ready_o),
    .host_valid_i (host_valid_i),
    .host_ready_o (host_ready_o),
    .rxf_valid_o  (rxf_valid_o),
    .rxf_data_o   (rxf_data_o),
    .rxf_ready_i  (rxf_ready_i),
    .tx_valid_o   (tx_valid_o),
    .tx_ready_i   (tx_ready_i)
);

// File: tb/tb_chmode_router.sv
`timescale 1ns/1ps
module tb_chmode_router;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] mode_i;
    logic       line_valid_i, line_break_i, host_valid_i;
    logic [7:0] line_data_i, host_data_i;
    logic       line_ready_o, host_ready_o;
    logic       rxf_valid_o, tx_valid_o;
    logic [7:0] rxf_data_o, tx_data_o;
    logic       rxf_ready_i, tx_ready_i;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    chmode_router dut (
        .clk(clk), .rst(rst), .mode_i(mode_i),
        .line_valid_i(line_valid_i), .line_data_i(line_data_i),
        .line_break_i(line_break_i), .line_ready_o(line_ready_o),
        .host_valid_i(host_valid_i), .host_data_i(host_data_i),
        .host_ready_o(host_ready_o),
        .rxf_valid_o(rxf_valid_o), .rxf_data_o(rxf_data_o), .rxf_ready_i(rxf_ready_i),
        .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_ready_i(tx_ready_i)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected routing per requirement R2..R6 for mode m
    task automatic check_all(input int m, input string tag);
        logic lrx, ltx, hrx, htx, erv, etv, elr, ehr;
        lrx = (m == 0) || (m == 1);
        ltx = ((m == 1) || (m == 3)) && !line_break_i;
        hrx = (m == 2);
        htx = (m == 0);
        elr = (!lrx || rxf_ready_i) && (!ltx || tx_ready_i);
        ehr = (!hrx || rxf_ready_i) && (!htx || tx_ready_i);
        erv = (line_valid_i && lrx && (!ltx || tx_ready_i)) || (host_valid_i && hrx);
        etv = (line_valid_i && ltx && (!lrx || rxf_ready_i)) || (host_valid_i && htx);
        chk({tag, " R7 R9 line_ready"}, {7'd0, line_ready_o}, {7'd0, elr});
        chk({tag, " R9 host_ready"}, {7'd0, host_ready_o}, {7'd0, ehr});
        chk({tag, " rxf_valid"}, {7'd0, rxf_valid_o}, {7'd0, erv});
        chk({tag, " tx_valid"}, {7'd0, tx_valid_o}, {7'd0, etv});
        if (erv)
            chk({tag, " R6 rxf_data"}, rxf_data_o,
                hrx ? host_data_i : (line_break_i ? 8'h00 : line_data_i));
        if (etv)
            chk({tag, " tx_data"}, tx_data_o, htx ? host_data_i : line_data_i);
    endtask

    initial begin
        rst = 1'b1; mode_i = 2'd3;
        line_valid_i = 0; line_break_i = 0; host_valid_i = 0;
        line_data_i = 8'h00; host_data_i = 8'h00;
        rxf_ready_i = 1; tx_ready_i = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        line_valid_i = 1; line_data_i = 8'h5A;
        @(posedge clk);
        @(negedge clk);
        // R1: still in reset with mode_i=3, routing must be normal
        check_all(0, "R1 reset");
        rst = 1'b0; line_valid_i = 0;
        @(posedge clk);

        for (int m = 0; m < 4; m++) begin
            @(negedge clk);
            line_valid_i = 0; host_valid_i = 0; mode_i = 2'(m);
            @(posedge clk);
            for (int c = 0; c < 32; c++) begin
                @(negedge clk);
                line_valid_i = c[0];
                host_valid_i = c[1];
                line_break_i = c[2];
                rxf_ready_i  = c[3];
                tx_ready_i   = c[4];
                line_data_i  = 8'(8'hA1 + c * 7 + m * 3);
                host_data_i  = 8'(8'h3C ^ (c * 5 + m));
                #2;
                case (m)
                    0: check_all(m, "R2 normal");
                    1: check_all(m, "R3 echo");
                    2: check_all(m, "R4 local");
                    default: check_all(m, "R5 remote");
                endcase
            end
        end

        // R8: mode change held off while a line byte is stalled
        @(negedge clk);
        line_valid_i = 0; host_valid_i = 0; line_break_i = 0;
        mode_i = 2'd0; rxf_ready_i = 1; tx_ready_i = 1;
        @(posedge clk);
        @(negedge clk);
        line_valid_i = 1; line_data_i = 8'hC3; rxf_ready_i = 0;
        @(posedge clk);
        @(negedge clk);
        mode_i = 2'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 stalled keeps rx route", {7'd0, rxf_valid_o}, 8'd1);
        chk("R8 stalled no tx", {7'd0, tx_valid_o}, 8'd0);
        rxf_ready_i = 1;
        #2;
        chk("R8 stalled byte completes", {7'd0, line_ready_o}, 8'd1);
        chk("R8 stalled byte data", rxf_data_o, 8'hC3);
        @(posedge clk);
        @(negedge clk);
        line_data_i = 8'h7E;
        #2;
        chk("R8 next byte to tx", {7'd0, tx_valid_o}, 8'd1);
        chk("R8 next byte tx data", tx_data_o, 8'h7E);
        chk("R8 next byte not rx", {7'd0, rxf_valid_o}, 8'd0);
        line_valid_i = 0;
        @(posedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule